// File: doc/BRIEF.md
# Block-Ack Window Tracker

This block follows the delivery state of one transmit queue that runs under block-acknowledge tracking. The transmit engine reports each frame it sends by sequence number. The tracker keeps a sliding window of up to 64 consecutive sequence numbers starting at the window base. For every slot in the window it holds a sent flag and an acknowledged flag. When a block-ack report arrives, it carries a starting sequence number and a 64-bit bitmap. The tracker marks the frames that were delivered, and it queues a retransmit request for every frame the report covers that was sent but not acknowledged.

Deliveries may be confirmed in any order. The window base only moves forward over an unbroken run of acknowledged slots that begins at the base. It moves one slot per cycle, and each slot it leaves produces a completion pulse that carries that slot's sequence number. Pending retransmits are offered one at a time on a valid/ready port, lowest sequence offset first. Two 7-bit configuration inputs set the usable window width and the maximum number of frames in flight.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset, `win_base` is 0 and `rtx_valid`, `cmp_valid` and `snd_err` are all low.
- R2: A send notice is accepted when its offset `(snd_seq - win_base) mod 4096` is below min(`cfg_win_size`, 64). Any other send notice raises `snd_err` for one cycle, on the cycle after it is sampled, and does not change the tracker.
- R3: A send notice for a slot that is not yet marked sent is rejected with `snd_err` while the number of sent slots is at least `cfg_frame_limit`. A repeated notice for a slot that is already sent is still accepted.
- R4: Bitmap bit i of a report refers to sequence `(ba_ssn + i) mod 4096`. The bit acknowledges that slot only if the slot is inside the current window and is already marked sent. Bits for unsent slots or slots outside the window have no effect.
- R5: While the slot at the base is acknowledged, the base advances by one each cycle, and `cmp_valid` pulses with `cmp_seq` equal to the base being left. An acknowledged slot above an unacknowledged one does not complete until the gap is filled.
- R6: A report makes a retransmit pending for every in-window slot it covers that is sent but not acknowledged. `rtx_valid` rises on the cycle after the report is sampled.
- R7: Pending retransmits are presented lowest offset first. `rtx_seq` is held while `rtx_ready` is low, and exactly one request is removed per handshake.
- R8: An acknowledgement that arrives for a slot with a pending retransmit cancels that request.
- R9: Sequence arithmetic wraps modulo 4096. A report whose start lies numerically above the base still acknowledges the correct slots, and a send notice behind the base is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_win_size | input | 7 | Usable window width in slots (values above 64 act as 64) |
| cfg_frame_limit | input | 7 | Maximum number of sent slots held in the window |
| snd_valid | input | 1 | Send notice strobe |
| snd_seq | input | 12 | Sequence number of the frame just sent |
| snd_err | output | 1 | Send notice rejected (one cycle after the notice) |
| ba_valid | input | 1 | Block-ack report strobe |
| ba_ssn | input | 12 | Starting sequence number of the report |
| ba_bitmap | input | 64 | Acknowledge bits; bit i covers ba_ssn + i |
| rtx_valid | output | 1 | A retransmit request is offered |
| rtx_ready | input | 1 | Consumer accepts the offered request |
| rtx_seq | output | 12 | Sequence number to retransmit |
| cmp_valid | output | 1 | One slot completed and left the window |
| cmp_seq | output | 12 | Sequence number of the completed slot |
| win_base | output | 12 | Current window base sequence number |

## Verification
A send notice sampled at edge k produces `snd_err` after edge k. A report sampled at edge k updates the acknowledged and pending flags at that edge, so `rtx_valid`/`rtx_seq` reflect it right after edge k. The first slide happens at edge k+1, so the first completion is visible after edge k+1, and each further completion follows one edge later. Each directed task drives its inputs on the falling edge and reads the outputs on later falling edges that match these counts. A burst of completions is therefore checked one edge at a time, and each retransmit handshake is checked before the rising edge that consumes it.

// File: rtl/bawt_pkg.sv
package bawt_pkg;
  localparam int SEQ_W   = 12;
  localparam int WIN_MAX = 64;
  localparam int CFG_W   = 7;
  localparam int IDX_W   = $clog2(WIN_MAX);

  typedef logic [SEQ_W-1:0]   seq_t;
  typedef logic [WIN_MAX-1:0] win_vec_t;
  typedef logic [CFG_W-1:0]   cfg_t;

  // Modular distance of a from b in sequence space.
  function automatic seq_t seq_dist(input seq_t a, input seq_t b);
    return a - b;
  endfunction

  // Clamp a programmed window width to the tracked maximum.
  function automatic cfg_t win_clamp(input cfg_t c);
    return (int'(c) > WIN_MAX) ? cfg_t'(WIN_MAX) : c;
  endfunction

  function automatic cfg_t pop_count(input win_vec_t v);
    cfg_t n;
    n = '0;
    for (int i = 0; i < WIN_MAX; i++) n = n + cfg_t'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/bawt_admit.sv
module bawt_admit
  import bawt_pkg::*;
#(
  parameter int SEQ_BITS = SEQ_W,
  parameter int WIN_SLOTS = WIN_MAX
) (
  input  logic [SEQ_BITS-1:0]  base,
  input  logic [WIN_SLOTS-1:0] sent_vec,
  input  cfg_t                 win_eff,
  input  cfg_t                 frame_lim,
  input  logic                 req,
  input  logic [SEQ_BITS-1:0]  seq,
  output logic                 accept,
  output logic                 reject,
  output logic [WIN_SLOTS-1:0] set_vec
);
  localparam int IW = $clog2(WIN_SLOTS);

  logic [SEQ_BITS-1:0] off;
  logic                in_win, dup, room;

  always_comb begin
    off     = seq_dist(seq, base);
    in_win  = off < SEQ_BITS'(win_eff);
    dup     = in_win && sent_vec[off[IW-1:0]];
    room    = pop_count(sent_vec) < frame_lim;
    accept  = req && in_win && (dup || room);
    reject  = req && !accept;
    set_vec = accept ? (WIN_SLOTS'(1) << off[IW-1:0]) : '0;
  end
endmodule

// File: rtl/bawt_bamap.sv
module bawt_bamap
  import bawt_pkg::*;
#(
  parameter int SEQ_BITS = SEQ_W,
  parameter int WIN_SLOTS = WIN_MAX
) (
  input  logic [SEQ_BITS-1:0]  base,
  input  logic [SEQ_BITS-1:0]  ssn,
  input  logic [WIN_SLOTS-1:0] bitmap,
  input  cfg_t                 win_eff,
  output logic [WIN_SLOTS-1:0] cover_vec,
  output logic [WIN_SLOTS-1:0] hit_vec
);
  localparam int IW = $clog2(WIN_SLOTS);

  for (genvar j = 0; j < WIN_SLOTS; j++) begin : g_slot
    logic [SEQ_BITS-1:0] d;
    logic                in_win;
    always_comb begin
      d            = seq_dist(base + SEQ_BITS'(j), ssn);
      in_win       = j < int'(win_eff);
      cover_vec[j] = in_win && (d < SEQ_BITS'(WIN_SLOTS));
      hit_vec[j]   = cover_vec[j] && bitmap[d[IW-1:0]];
    end
  end
endmodule

// File: rtl/bawt_pick.sv
module bawt_pick #(
  parameter int WIN_SLOTS = 64
) (
  input  logic [WIN_SLOTS-1:0]         vec,
  output logic                         found,
  output logic [$clog2(WIN_SLOTS)-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = WIN_SLOTS - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = ($clog2(WIN_SLOTS))'(i);
      end
    end
  end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker
  import bawt_pkg::*;
#(
  parameter int SEQ_BITS = SEQ_W,
  parameter int WIN_SLOTS = WIN_MAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_W-1:0]     cfg_win_size,
  input  logic [CFG_W-1:0]     cfg_frame_limit,
  input  logic                 snd_valid,
  input  logic [SEQ_BITS-1:0]  snd_seq,
  output logic                 snd_err,
  input  logic                 ba_valid,
  input  logic [SEQ_BITS-1:0]  ba_ssn,
  input  logic [WIN_SLOTS-1:0] ba_bitmap,
  output logic                 rtx_valid,
  input  logic                 rtx_ready,
  output logic [SEQ_BITS-1:0]  rtx_seq,
  output logic                 cmp_valid,
  output logic [SEQ_BITS-1:0]  cmp_seq,
  output logic [SEQ_BITS-1:0]  win_base
);
  localparam int IW = $clog2(WIN_SLOTS);

  logic [SEQ_BITS-1:0]  base_q, cmp_seq_q;
  logic [WIN_SLOTS-1:0] sent_q, ack_q, pend_q;
  logic                 cmp_q, err_q;

  cfg_t                 win_eff;
  logic                 snd_ok, snd_bad;
  logic [WIN_SLOTS-1:0] snd_set, cover_vec, hit_vec;
  logic                 pick_found;
  logic [IW-1:0]        pick_idx;

  // Named internal events
  logic                 slide_ev, take_ev;
  logic [WIN_SLOTS-1:0] take_vec, ack_new, sent_u, ack_u, pend_u;

  assign win_eff = win_clamp(cfg_win_size);

  bawt_admit #(.SEQ_BITS(SEQ_BITS), .WIN_SLOTS(WIN_SLOTS)) u_admit (
    .base(base_q), .sent_vec(sent_q), .win_eff(win_eff), .frame_lim(cfg_frame_limit),
    .req(snd_valid), .seq(snd_seq), .accept(snd_ok), .reject(snd_bad), .set_vec(snd_set)
  );

  bawt_bamap #(.SEQ_BITS(SEQ_BITS), .WIN_SLOTS(WIN_SLOTS)) u_bamap (
    .base(base_q), .ssn(ba_ssn), .bitmap(ba_bitmap), .win_eff(win_eff),
    .cover_vec(cover_vec), .hit_vec(hit_vec)
  );

  bawt_pick #(.WIN_SLOTS(WIN_SLOTS)) u_pick (
    .vec(pend_q), .found(pick_found), .idx(pick_idx)
  );

  assign rtx_valid = pick_found;
  assign rtx_seq   = base_q + SEQ_BITS'(pick_idx);
  assign take_ev   = rtx_valid && rtx_ready;
  assign take_vec  = take_ev ? (WIN_SLOTS'(1) << pick_idx) : '0;
  assign slide_ev  = ack_q[0];
  assign ack_new   = ba_valid ? (hit_vec & sent_q) : '0;

  always_comb begin
    sent_u = sent_q | snd_set;
    ack_u  = ack_q | ack_new;
    pend_u = pend_q & ~take_vec;
    if (ba_valid) pend_u = (pend_u & ~cover_vec) | (cover_vec & sent_q & ~ack_u);
    pend_u = pend_u & ~ack_u;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      sent_q    <= '0;
      ack_q     <= '0;
      pend_q    <= '0;
      cmp_q     <= 1'b0;
      cmp_seq_q <= '0;
      err_q     <= 1'b0;
    end else begin
      err_q     <= snd_bad;
      cmp_q     <= slide_ev;
      cmp_seq_q <= base_q;
      if (slide_ev) begin
        base_q <= base_q + SEQ_BITS'(1);
        sent_q <= sent_u >> 1;
        ack_q  <= ack_u >> 1;
        pend_q <= pend_u >> 1;
      end else begin
        sent_q <= sent_u;
        ack_q  <= ack_u;
        pend_q <= pend_u;
      end
    end
  end

  assign snd_err   = err_q;
  assign cmp_valid = cmp_q;
  assign cmp_seq   = cmp_seq_q;
  assign win_base  = base_q;

  logic unused_ok;
  assign unused_ok = snd_ok;
endmodule

// File: rtl/bawt_checker.sv
module bawt_checker #(
  parameter int SEQ_BITS = 12,
  parameter int WIN_SLOTS = 64
) (
  input logic                clk,
  input logic                rst_n,
  input logic                snd_valid,
  input logic                snd_err,
  input logic                ba_valid,
  input logic                rtx_valid,
  input logic                rtx_ready,
  input logic [SEQ_BITS-1:0] rtx_seq,
  input logic                cmp_valid,
  input logic [SEQ_BITS-1:0] cmp_seq,
  input logic [SEQ_BITS-1:0] win_base
);
  logic [SEQ_BITS-1:0] rtx_off;
  assign rtx_off = rtx_seq - win_base;

  p_err_follows_send_r2: assert property (@(posedge clk) disable iff (!rst_n)
    snd_err |-> $past(snd_valid));

  p_cmp_matches_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid |-> (win_base == cmp_seq + SEQ_BITS'(1)));

  p_base_single_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (win_base != $past(win_base)) |-> (win_base == $past(win_base) + SEQ_BITS'(1)) && cmp_valid);

  p_rtx_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rtx_valid |-> (rtx_off < SEQ_BITS'(WIN_SLOTS)));

  p_rtx_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rtx_valid && !rtx_ready && !ba_valid) |=> (rtx_valid && $stable(rtx_seq)));
endmodule

bind ba_window_tracker bawt_checker #(.SEQ_BITS(SEQ_BITS), .WIN_SLOTS(WIN_SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .snd_valid(snd_valid), .snd_err(snd_err), .ba_valid(ba_valid),
  .rtx_valid(rtx_valid), .rtx_ready(rtx_ready), .rtx_seq(rtx_seq),
  .cmp_valid(cmp_valid), .cmp_seq(cmp_seq), .win_base(win_base)
);

// File: tb/ba_window_tracker_tb.sv
module ba_window_tracker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  cfg_win_size = 7'd64;
  logic [6:0]  cfg_frame_limit = 7'd64;
  logic        snd_valid = 1'b0;
  logic [11:0] snd_seq = '0;
  logic        snd_err;
  logic        ba_valid = 1'b0;
  logic [11:0] ba_ssn = '0;
  logic [63:0] ba_bitmap = '0;
  logic        rtx_valid;
  logic        rtx_ready = 1'b0;
  logic [11:0] rtx_seq;
  logic        cmp_valid;
  logic [11:0] cmp_seq;
  logic [11:0] win_base;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  ba_window_tracker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_win_size(cfg_win_size), .cfg_frame_limit(cfg_frame_limit),
    .snd_valid(snd_valid), .snd_seq(snd_seq), .snd_err(snd_err),
    .ba_valid(ba_valid), .ba_ssn(ba_ssn), .ba_bitmap(ba_bitmap),
    .rtx_valid(rtx_valid), .rtx_ready(rtx_ready), .rtx_seq(rtx_seq),
    .cmp_valid(cmp_valid), .cmp_seq(cmp_seq), .win_base(win_base)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(input int seq, input int exp_err, input string req);
    @(negedge clk);
    snd_valid = 1'b1;
    snd_seq   = 12'(seq);
    @(negedge clk);
    snd_valid = 1'b0;
    chk(req, $sformatf("snd_err for seq %0d", seq), int'(snd_err), exp_err);
  endtask

  task automatic report(input int ssn, input logic [63:0] bm);
    @(negedge clk);
    ba_valid  = 1'b1;
    ba_ssn    = 12'(ssn);
    ba_bitmap = bm;
    @(negedge clk);
    ba_valid  = 1'b0;
  endtask

  // Expect completions on consecutive cycles, starting one edge from now.
  task automatic expect_cmps(input int first, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(req, "cmp_valid", int'(cmp_valid), 1);
      chk(req, "cmp_seq", int'(cmp_seq), first + k);
    end
    @(negedge clk);
    chk(req, "cmp_valid after burst", int'(cmp_valid), 0);
    chk(req, "win_base after burst", int'(win_base), first + n);
  endtask

  task automatic drain(input int seqs[$], input string req);
    foreach (seqs[k]) begin
      chk(req, "rtx_valid", int'(rtx_valid), 1);
      chk(req, $sformatf("rtx_seq #%0d", k), int'(rtx_seq), seqs[k]);
      rtx_ready = 1'b1;
      @(negedge clk);
    end
    rtx_ready = 1'b0;
    chk(req, "rtx_valid after drain", int'(rtx_valid), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", "win_base", int'(win_base), 0);
    chk("R1", "rtx_valid", int'(rtx_valid), 0);
    chk("R1", "cmp_valid", int'(cmp_valid), 0);
    chk("R1", "snd_err", int'(snd_err), 0);
  endtask

  task automatic t_admit;
    for (int s = 0; s < 8; s++) send(s, 0, "R2");
    send(70, 1, "R2");
    cfg_win_size = 7'd8;
    send(8, 1, "R2");
    send(5, 0, "R2");
    cfg_win_size = 7'd64;
  endtask

  task automatic t_limit;
    cfg_frame_limit = 7'd8;
    send(9, 1, "R3");
    send(3, 0, "R3");
    cfg_frame_limit = 7'd64;
  endtask

  task automatic t_out_of_order;
    report(0, 64'h0C);
    chk("R6", "rtx_valid one cycle after report", int'(rtx_valid), 1);
    @(negedge clk);
    chk("R5", "no completion with base unacked", int'(cmp_valid), 0);
    chk("R5", "base held", int'(win_base), 0);
    @(negedge clk);
    chk("R7", "rtx_seq held without ready", int'(rtx_seq), 0);
    drain('{0, 1, 4, 5, 6, 7}, "R7");
  endtask

  task automatic t_slide;
    report(0, 64'h03);
    expect_cmps(0, 4, "R5");
    chk("R6", "re-request of uncovered-acked slot", int'(rtx_seq), 4);
    report(4, 64'h0F);
    chk("R8", "acks cancel pending rtx", int'(rtx_valid), 0);
    expect_cmps(4, 4, "R5");
  endtask

  task automatic t_ignore;
    report(8, 64'h01);
    repeat (2) @(negedge clk);
    chk("R4", "ack of unsent slot ignored (base)", int'(win_base), 8);
    chk("R4", "ack of unsent slot ignored (cmp)", int'(cmp_valid), 0);
    send(8, 0, "R4");
    send(9, 0, "R4");
    send(10, 0, "R4");
    cfg_win_size = 7'd2;
    report(8, 64'h07);
    chk("R4", "out-of-window slot not requested", int'(rtx_valid), 0);
    expect_cmps(8, 2, "R4");
    cfg_win_size = 7'd64;
  endtask

  task automatic t_cancel;
    send(11, 0, "R8");
    report(10, 64'h0);
    chk("R6", "rtx_seq lowest", int'(rtx_seq), 10);
    report(10, 64'h1);
    chk("R8", "rtx moved past cancelled", int'(rtx_seq), 11);
    expect_cmps(10, 1, "R8");
    drain('{11}, "R8");
  endtask

  task automatic t_wrap;
    report(4090, 64'h1 << 17);
    expect_cmps(11, 1, "R9");
    send(4095, 1, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_admit();
    t_limit();
    t_out_of_order();
    t_slide();
    t_ignore();
    t_cancel();
    t_wrap();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule